// File: doc/BRIEF.md
# Byte-Wide Host Register Staging Port

This block connects an 8-bit asynchronous host port to a bank of 32-bit control registers in the core clock domain. The host writes a control word one byte lane at a time into a 32-bit staging word. It then issues a commit write. The data byte of that commit write names the control register that receives the complete staged word. The copy takes place in the core clock domain. The write strobe reaches that domain through a two-flop synchronizer and a rising-edge detector. The core sees every control register in parallel, together with a one-cycle load pulse and the index that was just loaded.

Readback takes two steps. The host first writes a word pointer. It then holds the read line and chip enable low, and the three address lines act as a combinational byte selector over the chosen word. The data pins are driven only during such a read and are released at all other times. The host must leave at least four core cycles between a commit and the next staging write. Its strobe rate must stay at or below a quarter of the core clock.

Top module: `host_word_stager`

## Requirements
- R1: After reset every control register reads zero, the load pulse is low and the data bus is not driven.
- R2: A qualified write with host_sel equal to 0, 1, 2 or 3 stores the data byte into staging bits 7:0, 15:8, 23:16 or 31:24. The other lanes keep their values.
- R3: A qualified write with host_sel = 4 copies the whole staged word into the control register whose index equals the data byte. No other register changes.
- R4: The copy and a one-cycle cw_load_pulse, with cw_load_index set to the written index, appear at the third rising core edge after the rising edge of host_wr_n.
- R5: A commit whose index byte is 16 or more changes no register and produces no load pulse.
- R6: While host_en_n is high, a write strobe has no effect on staging, on the pointer or on the registers.
- R7: A write strobe issued while host_rd_n is low has no effect.
- R8: A qualified write with host_sel = 5 loads the low 5 bits of the data byte into the readback pointer. With host_rd_n and host_en_n both low, host_sel values 0 to 3 then place bytes 0 to 3 of the selected register on host_bus, with no strobe needed.
- R9: host_bus is high impedance whenever host_rd_n or host_en_n is high.
- R10: A read returns 0x00 when the pointer is 16 or more, or when host_sel is 4 to 7.
- R11: A commit leaves the staged word unchanged, so the same word can be committed to several registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 3 | Host address: byte lane, commit, pointer or read byte select |
| host_bus | inout | 8 | Bidirectional host data |
| host_en_n | input | 1 | Chip enable, active low |
| host_rd_n | input | 1 | Low selects a read and enables the drivers |
| host_wr_n | input | 1 | Write strobe; data is taken on its rising edge |
| cw_words | output | 512 | All control registers, register i at bits 32*i+31:32*i |
| cw_load_pulse | output | 1 | One core cycle high when a register is loaded |
| cw_load_index | output | 4 | Index of the register loaded by the latest commit |

## Verification
The staging writes and pointer writes take effect at the rising edge of the host strobe. The bench therefore gives each strobe a fixed low time and recovery time and reads the result through a later commit or readback. A commit lands at the third rising core edge after the strobe edge. The bench samples the pulse on the falling edge after each of the first four core edges and expects it only after the third. For bulk checks it waits five cycles before it compares cw_words. Readback is combinational, so the bench samples host_bus one time unit after it sets the selector, and it does so with no strobe activity.

// File: rtl/hws_pkg.sv
package hws_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = 4;
  localparam int unsigned WORD_W  = BYTE_W * LANES;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_LANE0  = 3'd0,
    SEL_LANE1  = 3'd1,
    SEL_LANE2  = 3'd2,
    SEL_LANE3  = 3'd3,
    SEL_COMMIT = 3'd4,
    SEL_RBPTR  = 3'd5,
    SEL_SPARE6 = 3'd6,
    SEL_SPARE7 = 3'd7
  } host_sel_e;
endpackage

// File: rtl/hws_host_regs.sv
module hws_host_regs
  import hws_pkg::*;
#(
  parameter int unsigned RB_W = 5
) (
  input  logic                rst_n,
  input  logic                host_wr_n,
  input  logic [SEL_W-1:0]    host_sel,
  input  logic [BYTE_W-1:0]   host_din,
  input  logic                host_en_n,
  input  logic                host_rd_n,
  output logic [WORD_W-1:0]   stage_q,
  output logic                commit_q,
  output logic [BYTE_W-1:0]   commit_idx_q,
  output logic [RB_W-1:0]     rb_ptr_q
);
  logic                wr_ok;
  logic [LANES-1:0]    lane_hit;
  logic [WORD_W-1:0]   stage_d;
  logic                commit_d;
  logic [BYTE_W-1:0]   commit_idx_d;
  logic [RB_W-1:0]     rb_ptr_d;

  assign wr_ok = !host_en_n && host_rd_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_hit[l] = wr_ok && (host_sel == SEL_W'(l));
    assign stage_d[l*BYTE_W +: BYTE_W] = lane_hit[l] ? host_din
                                                     : stage_q[l*BYTE_W +: BYTE_W];
  end

  always_comb begin
    commit_d     = wr_ok && (host_sel == SEL_COMMIT);
    commit_idx_d = commit_d ? host_din : commit_idx_q;
    rb_ptr_d     = (wr_ok && (host_sel == SEL_RBPTR)) ? host_din[RB_W-1:0] : rb_ptr_q;
  end

  always_ff @(posedge host_wr_n or negedge rst_n) begin
    if (!rst_n) begin
      stage_q      <= '0;
      commit_q     <= 1'b0;
      commit_idx_q <= '0;
      rb_ptr_q     <= '0;
    end else begin
      stage_q      <= stage_d;
      commit_q     <= commit_d;
      commit_idx_q <= commit_idx_d;
      rb_ptr_q     <= rb_ptr_d;
    end
  end
endmodule

// File: rtl/hws_wr_sync.sv
module hws_wr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              hist_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_chain
    if (s == 0) begin : g_first
      assign chain_d[s] = async_in;
    end else begin : g_next
      assign chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      hist_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      hist_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] && !hist_q;
endmodule

// File: rtl/hws_ctrl_bank.sv
module hws_ctrl_bank
  import hws_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic                        commit,
  input  logic [BYTE_W-1:0]           cmd_idx,
  input  logic [WORD_W-1:0]           stage,
  output logic [NUM_WORDS*WORD_W-1:0] words,
  output logic [NUM_WORDS-1:0]        word_we,
  output logic                        load_pulse,
  output logic [IDX_W-1:0]            load_index
);
  logic             in_range;
  logic             do_load;
  logic             pulse_d;
  logic [IDX_W-1:0] index_d;

  assign in_range = 32'(cmd_idx) < NUM_WORDS;
  assign do_load  = fire && commit && in_range;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    assign word_we[i] = do_load && (cmd_idx[IDX_W-1:0] == IDX_W'(i));
    assign word_d     = word_we[i] ? stage : word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign words[i*WORD_W +: WORD_W] = word_q;
  end

  always_comb begin
    pulse_d = do_load;
    index_d = do_load ? cmd_idx[IDX_W-1:0] : load_index;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pulse <= 1'b0;
      load_index <= '0;
    end else begin
      load_pulse <= pulse_d;
      load_index <= index_d;
    end
  end
endmodule

// File: rtl/hws_read_mux.sv
module hws_read_mux
  import hws_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned RB_W      = 5,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words,
  input  logic [RB_W-1:0]             rb_ptr,
  input  logic [SEL_W-1:0]            sel,
  output logic [BYTE_W-1:0]           rd_byte
);
  logic [IDX_W-1:0]  ptr_idx;
  logic              ptr_ok;
  logic [WORD_W-1:0] word_sel;

  assign ptr_idx = rb_ptr[IDX_W-1:0];
  assign ptr_ok  = 32'(rb_ptr) < NUM_WORDS;

  always_comb begin
    word_sel = ptr_ok ? words[ptr_idx*WORD_W +: WORD_W] : '0;
    if (sel[SEL_W-1]) rd_byte = '0;
    else              rd_byte = word_sel[sel[1:0]*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/host_word_stager.sv
module host_word_stager
  import hws_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 16,
  parameter int unsigned RB_W        = 5,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  host_sel,
  inout  wire  [7:0]                  host_bus,
  input  logic                        host_en_n,
  input  logic                        host_rd_n,
  input  logic                        host_wr_n,
  output logic [NUM_WORDS*32-1:0]     cw_words,
  output logic                        cw_load_pulse,
  output logic [IDX_W-1:0]            cw_load_index
);
  logic [1:0]           rst_sync_q;
  logic                 core_rst_n;
  logic [WORD_W-1:0]    stage_q;
  logic                 commit_q;
  logic [BYTE_W-1:0]    commit_idx_q;
  logic [RB_W-1:0]      rb_ptr_q;
  logic                 wr_rise;
  logic [NUM_WORDS-1:0] word_we;
  logic [BYTE_W-1:0]    rd_byte;
  logic                 drive_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  hws_host_regs #(.RB_W(RB_W)) u_host (
    .rst_n        (rst_n),
    .host_wr_n    (host_wr_n),
    .host_sel     (host_sel),
    .host_din     (host_bus),
    .host_en_n    (host_en_n),
    .host_rd_n    (host_rd_n),
    .stage_q      (stage_q),
    .commit_q     (commit_q),
    .commit_idx_q (commit_idx_q),
    .rb_ptr_q     (rb_ptr_q)
  );

  hws_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (host_wr_n),
    .rise     (wr_rise)
  );

  hws_ctrl_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .fire       (wr_rise),
    .commit     (commit_q),
    .cmd_idx    (commit_idx_q),
    .stage      (stage_q),
    .words      (cw_words),
    .word_we    (word_we),
    .load_pulse (cw_load_pulse),
    .load_index (cw_load_index)
  );

  hws_read_mux #(.NUM_WORDS(NUM_WORDS), .RB_W(RB_W)) u_rmux (
    .words   (cw_words),
    .rb_ptr  (rb_ptr_q),
    .sel     (host_sel),
    .rd_byte (rd_byte)
  );

  assign drive_en = !host_rd_n && !host_en_n;
  assign host_bus = drive_en ? rd_byte : 8'bzzzz_zzzz;
endmodule

// File: rtl/hws_chk.sv
module hws_chk #(
  parameter int unsigned NUM_WORDS = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input logic                    clk,
  input logic                    core_rst_n,
  input logic                    host_rd_n,
  input logic                    host_en_n,
  input logic                    drive_en,
  input logic [NUM_WORDS*32-1:0] cw_words,
  input logic                    cw_load_pulse,
  input logic [IDX_W-1:0]        cw_load_index,
  input logic [NUM_WORDS-1:0]    word_we
);
  // R3
  single_target_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0(word_we));

  // R3
  change_needs_pulse_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(cw_words) |-> cw_load_pulse);

  // R4
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    cw_load_pulse |=> !cw_load_pulse);

  // R4
  index_held_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cw_load_pulse |-> $stable(cw_load_index));

  // R9
  bus_released_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (host_rd_n || host_en_n) |-> !drive_en);
endmodule

bind host_word_stager hws_chk #(.NUM_WORDS(NUM_WORDS)) u_hws_chk (
  .clk           (clk),
  .core_rst_n    (core_rst_n),
  .host_rd_n     (host_rd_n),
  .host_en_n     (host_en_n),
  .drive_en      (drive_en),
  .cw_words      (cw_words),
  .cw_load_pulse (cw_load_pulse),
  .cw_load_index (cw_load_index),
  .word_we       (word_we)
);

// File: tb/tb_host_word_stager.sv
`timescale 1ns/1ps
module tb_host_word_stager;
  localparam int NW = 16;

  logic        clk;
  logic        rst_n;
  logic [2:0]  host_sel;
  logic        host_en_n, host_rd_n, host_wr_n;
  logic        tb_drive;
  logic [7:0]  tb_data;
  wire  [7:0]  host_bus;
  logic [NW*32-1:0] cw_words;
  logic        cw_load_pulse;
  logic [3:0]  cw_load_index;

  int checks, failures, pulse_cnt;
  logic [3:0]  last_idx;
  logic [31:0] exp_w [NW];
  logic [31:0] staged;
  logic [7:0]  rb;

  assign host_bus = tb_drive ? tb_data : 8'bzzzz_zzzz;

  host_word_stager dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_bus(host_bus),
    .host_en_n(host_en_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .cw_words(cw_words), .cw_load_pulse(cw_load_pulse), .cw_load_index(cw_load_index)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (cw_load_pulse) begin
      pulse_cnt <= pulse_cnt + 1;
      last_idx  <= cw_load_index;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d,
                            input logic en_n, input logic rd_n);
    @(negedge clk);
    host_sel = a; tb_data = d; tb_drive = rd_n; host_en_n = en_n; host_rd_n = rd_n;
    host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    host_en_n = 1'b1; host_rd_n = 1'b1; tb_drive = 1'b0;
  endtask

  task automatic stage_word(input logic [31:0] w);
    for (int l = 0; l < 4; l++) host_write(3'(l), w[l*8 +: 8], 1'b0, 1'b1);
    staged = w;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    tb_drive = 1'b0; host_sel = a; host_en_n = 1'b0; host_rd_n = 1'b0;
    #1 v = host_bus;
    @(negedge clk);
    host_en_n = 1'b1; host_rd_n = 1'b1;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NW; i++) check(req, 64'(cw_words[i*32 +: 32]), 64'(exp_w[i]));
  endtask

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pc;
    logic [31:0] p;
    checks = 0; failures = 0; pulse_cnt = 0; last_idx = '0;
    rst_n = 1'b0; host_sel = '0; host_en_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    tb_drive = 1'b0; tb_data = '0; staged = '0;
    for (int i = 0; i < NW; i++) exp_w[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", 64'(cw_words == '0), 64'd1);
    check("R1", 64'(cw_load_pulse), 64'd0);
    check("R1", 64'(host_bus === 8'bzzzz_zzzz), 64'd1);

    // R2 R3 sweep every register with a distinct pattern
    for (int w = 0; w < NW; w++) begin
      p = 32'h1F2E3D4C + 32'(w) * 32'h01030507;
      stage_word(p);
      host_write(3'd4, 8'(w), 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      exp_w[w] = p;
      check("R3", 64'(pulse_cnt), 64'(w + 1));
      check("R3", 64'(last_idx), 64'(w));
    end
    check_all("R2");

    // R8 readback of all bytes of all registers
    for (int w = 0; w < NW; w++) begin
      host_write(3'd5, 8'(w), 1'b0, 1'b1);
      for (int s = 0; s < 4; s++) begin
        host_read(3'(s), rb);
        check("R8", 64'(rb), 64'(exp_w[w][s*8 +: 8]));
      end
    end

    // R10 pointer out of range, selector above 3
    host_write(3'd5, 8'd16, 1'b0, 1'b1);
    host_read(3'd0, rb);
    check("R10", 64'(rb), 64'd0);
    host_write(3'd5, 8'd3, 1'b0, 1'b1);
    host_read(3'd5, rb);
    check("R10", 64'(rb), 64'd0);
    host_read(3'd7, rb);
    check("R10", 64'(rb), 64'd0);

    // R9 bus released when either control is high
    @(negedge clk);
    host_en_n = 1'b1; host_rd_n = 1'b0; #1;
    check("R9", 64'(host_bus === 8'bzzzz_zzzz), 64'd1);
    host_en_n = 1'b0; host_rd_n = 1'b1; #1;
    check("R9", 64'(host_bus === 8'bzzzz_zzzz), 64'd1);
    host_en_n = 1'b1;

    // R5 out-of-range commit index
    pc = pulse_cnt;
    stage_word(32'hDEADBEEF);
    host_write(3'd4, 8'd16, 1'b0, 1'b1);
    host_write(3'd4, 8'd200, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R5", 64'(pulse_cnt), 64'(pc));
    check_all("R5");

    // R4 cycle-exact commit timing, R11 staged word kept after commit
    @(negedge clk);
    host_sel = 3'd4; tb_data = 8'd2; tb_drive = 1'b1; host_en_n = 1'b0; host_rd_n = 1'b1;
    host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1;
    @(negedge clk); check("R4", 64'(cw_load_pulse), 64'd0);
    @(negedge clk); check("R4", 64'(cw_load_pulse), 64'd0);
    @(negedge clk); check("R4", 64'(cw_load_pulse), 64'd1);
    check("R4", 64'(cw_load_index), 64'd2);
    @(negedge clk); check("R4", 64'(cw_load_pulse), 64'd0);
    host_en_n = 1'b1; tb_drive = 1'b0;
    exp_w[2] = staged;
    host_write(3'd4, 8'd7, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    exp_w[7] = staged;
    check("R11", 64'(cw_words[7*32 +: 32]), 64'(32'hDEADBEEF));
    check_all("R11");

    // R6 chip enable high: lane write and commit ignored
    pc = pulse_cnt;
    host_write(3'd0, 8'h55, 1'b1, 1'b1);
    host_write(3'd4, 8'd9, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check("R6", 64'(pulse_cnt), 64'(pc));
    host_write(3'd4, 8'd9, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    exp_w[9] = staged;
    check("R6", 64'(cw_words[9*32 +: 32]), 64'(32'hDEADBEEF));

    // R7 strobe with read line low ignored
    pc = pulse_cnt;
    host_write(3'd3, 8'h66, 1'b0, 1'b0);
    host_write(3'd4, 8'd10, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R7", 64'(pulse_cnt), 64'(pc));
    host_write(3'd4, 8'd10, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    exp_w[10] = staged;
    check("R7", 64'(cw_words[10*32 +: 32]), 64'(32'hDEADBEEF));
    check_all("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule